// File: doc/BRIEF.md
# Chainable Serial Register Port

This block is the serial slave front end of a multichannel register bank. A host frames each transfer with an active-low select line. While the select line is low, every serial clock shifts one data bit into a 24-bit input word, most significant bit first. When the select line rises after a full word, the word is decoded. A write frame produces a one-cycle write strobe that carries the channel address, the register select and the 12-bit value, and it updates an internal register file. A read frame arms a readback. During the following frame the selected register's value, together with the echoed request header, is shifted out on the serial output.

When chaining is enabled, the serial output repeats the input stream 24 clocks later. Several ports can then share one select and one clock, with each output wired to the next port's input. A frame of 24 × N clocks loads all N ports at once. A frame that ends before 24 clocks is dropped. When chaining is disabled, a frame longer than 24 clocks keeps only its last 24 bits.

The select, clock and data pins are brought into a faster system clock through flop synchronisers, and all edge detection happens in that clock domain. Input data is taken on the serial clock's falling edge. The serial output changes after the rising edge, so it is stable when the next falling edge samples it.

Top module: `chain_regport`

## Requirements
- R1: After reset, the serial output is low and the write strobe is low.
- R2: A 24-clock frame with bit 22 = 0 and a non-zero select in bits 15:14 produces exactly one one-cycle write strobe. The strobe carries address = bits 21:16, select = bits 15:14 and data = bits 11:0.
- R3: A frame that ends after fewer than 24 serial clocks produces no strobe and leaves the register file unchanged.
- R4: With chaining enabled, from the 25th clock of a frame onward the serial output sampled before each falling edge equals the input bit taken 24 clocks earlier. Three chained ports given 72 clocks each receive their own word, with the last word sent going to the first port.
- R5: With chaining disabled, the serial output stays low in every frame that is not a readback frame, and while the select line is high.
- R6: With chaining disabled, a frame longer than 24 clocks is decoded from its last 24 bits only.
- R7: A frame with bit 22 = 1 is a read request. Its bits 11:0 are ignored. During the next frame the output, sampled before each falling edge and most significant bit first, is the request's bits 23:12 followed by the 12-bit content of the register chosen by address and select.
- R8: In a readback frame, the first output bit is present once the select line has fallen, before any serial clock edge.
- R9: Read requests and frames with select 00, including the all-zero word, produce no write strobe.
- R10: Serial clock edges while the select line is high shift nothing, produce no strobe and leave the output low.
- R11: The select encoding is 01 = gain register, 10 = offset register and 11 = data register. A write to an address at or above NCH is dropped with no strobe, and a read of such an address returns a zero value field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in, taken on the serial clock falling edge |
| chain_en_i | input | 1 | High enables shift-through to the serial output |
| sdo_o | output | 1 | Serial data out, changes after the serial clock rising edge |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 6 | Channel address of the write |
| wr_sel_o | output | 2 | Register select of the write |
| wr_data_o | output | 12 | Value of the write |

## Verification
The bench builds three ports with the default NCH = 8 and SYNC_STAGES = 2 and wires them into a chain. With NCH = 8, addresses 8 and above can be reached by the 6-bit address field, so dropped out-of-range writes and zero-valued out-of-range reads can be exercised. Chaining three instances makes a 72-clock frame necessary, which checks both the per-port word placement and the 24-bit-delayed shift-through. The serial clock half period of 12 system cycles leaves room for the synchroniser latency across two hops of the chain.

// File: rtl/crp_pkg.sv
package crp_pkg;
  localparam int FRAME_W  = 24;
  localparam int DATA_W   = 12;
  localparam int ADDR_W   = 6;
  localparam int SEL_W    = 2;
  localparam int RW_POS   = 22;
  localparam int ADDR_LSB = 16;
  localparam int SEL_LSB  = 14;
  localparam int ECHO_W   = FRAME_W - DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/crp_sync.sv
module crp_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/crp_frame.sv
module crp_frame
  import crp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic               sclk,
  input  logic               din,
  input  logic               chain_en,
  input  logic               rb_load,
  input  logic [FRAME_W-1:0] rb_word,
  output logic               sdo,
  output logic               frame_start,
  output logic               frame_good,
  output logic [FRAME_W-1:0] frame_word,
  output logic [CNT_W-1:0]   frame_cnt
);
  logic               sync_d, sclk_d, q, q_n, rb_mode, rb_mode_n, good, good_n;
  logic [FRAME_W-1:0] sr, sr_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic               sync_fall, sync_rise, sclk_fall, sclk_rise, framing;

  assign sync_fall = sync_d & ~sync_n;
  assign sync_rise = ~sync_d & sync_n;
  assign sclk_fall = sclk_d & ~sclk;
  assign sclk_rise = ~sclk_d & sclk;
  assign framing   = ~sync_n & ~sync_d;

  always_comb begin
    sr_n      = sr;
    cnt_n     = cnt;
    q_n       = q;
    rb_mode_n = rb_mode;
    good_n    = 1'b0;
    if (sync_fall) begin
      sr_n      = rb_load ? rb_word : '0;
      q_n       = rb_load & rb_word[FRAME_W-1];
      cnt_n     = '0;
      rb_mode_n = rb_load;
    end else if (framing) begin
      if (sclk_fall) begin
        sr_n = {sr[FRAME_W-2:0], din};
        if (cnt != CNT_W'(FRAME_W)) cnt_n = cnt + 1'b1;
      end
      if (sclk_rise) q_n = sr[FRAME_W-1];
    end
    if (sync_rise) begin
      good_n    = (cnt == CNT_W'(FRAME_W));
      rb_mode_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d  <= 1'b1;
      sclk_d  <= 1'b1;
      sr      <= '0;
      cnt     <= '0;
      q       <= 1'b0;
      rb_mode <= 1'b0;
      good    <= 1'b0;
    end else begin
      sync_d  <= sync_n;
      sclk_d  <= sclk;
      sr      <= sr_n;
      cnt     <= cnt_n;
      q       <= q_n;
      rb_mode <= rb_mode_n;
      good    <= good_n;
    end
  end

  assign sdo         = q & (chain_en | rb_mode);
  assign frame_start = sync_fall;
  assign frame_good  = good;
  assign frame_word  = sr;
  assign frame_cnt   = cnt;
endmodule

// File: rtl/crp_regs.sv
module crp_regs
  import crp_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               frame_good,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               wr_stb,
  output wr_req_t            wr_req,
  output logic               rb_pend,
  output logic [FRAME_W-1:0] rb_word
);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int IDX_W = CH_W + SEL_W;
  localparam int NENT  = 1 << IDX_W;

  logic [DATA_W-1:0] mem [NENT];
  logic [ADDR_W-1:0] f_addr;
  logic [SEL_W-1:0]  f_sel;
  logic [DATA_W-1:0] f_data;
  logic              f_rw, f_ok, do_wr, do_rd;
  logic [IDX_W-1:0]  f_idx, rb_idx, rb_idx_n;
  logic              rb_ok, rb_ok_n, pend_n, stb_n;
  logic [ECHO_W-1:0] echo, echo_n;
  wr_req_t           req_n;

  assign f_rw   = frame_word[RW_POS];
  assign f_addr = frame_word[ADDR_LSB +: ADDR_W];
  assign f_sel  = frame_word[SEL_LSB +: SEL_W];
  assign f_data = frame_word[DATA_W-1:0];
  assign f_ok   = {1'b0, f_addr} < (ADDR_W+1)'(NCH);
  assign f_idx  = {f_addr[CH_W-1:0], f_sel};
  assign do_wr  = frame_good & ~f_rw & (f_sel != '0) & f_ok;
  assign do_rd  = frame_good & f_rw;

  always_comb begin
    stb_n    = do_wr;
    req_n    = wr_req;
    pend_n   = rb_pend;
    echo_n   = echo;
    rb_idx_n = rb_idx;
    rb_ok_n  = rb_ok;
    if (do_wr) req_n = '{addr: f_addr, sel: f_sel, data: f_data};
    if (frame_start) pend_n = 1'b0;
    if (do_rd) begin
      pend_n   = 1'b1;
      echo_n   = frame_word[FRAME_W-1:DATA_W];
      rb_idx_n = f_idx;
      rb_ok_n  = f_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_req  <= '0;
      rb_pend <= 1'b0;
      echo    <= '0;
      rb_idx  <= '0;
      rb_ok   <= 1'b0;
    end else begin
      wr_stb  <= stb_n;
      wr_req  <= req_n;
      rb_pend <= pend_n;
      echo    <= echo_n;
      rb_idx  <= rb_idx_n;
      rb_ok   <= rb_ok_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) mem[e] <= '0;
    end else if (do_wr) begin
      mem[f_idx] <= f_data;
    end
  end

  assign rb_word = {echo, rb_ok ? mem[rb_idx] : {DATA_W{1'b0}}};
endmodule

// File: rtl/chain_regport.sv
module chain_regport
  import crp_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_n_i,
  input  logic        sclk_i,
  input  logic        din_i,
  input  logic        chain_en_i,
  output logic        sdo_o,
  output logic        wr_stb_o,
  output logic [5:0]  wr_addr_o,
  output logic [1:0]  wr_sel_o,
  output logic [11:0] wr_data_o
);
  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  logic [2:0]         pins_q;
  logic               sync_q, sclk_q, din_q;
  logic               frame_start, frame_good, rb_pend;
  logic [FRAME_W-1:0] frame_word, rb_word;
  logic [CNT_W-1:0]   frame_cnt;
  wr_req_t            wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  crp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d({sync_n_i, sclk_i, din_i}), .q(pins_q)
  );
  assign {sync_q, sclk_q, din_q} = pins_q;

  crp_frame u_frame (
    .clk(clk), .rst_n(rst_n_s), .sync_n(sync_q), .sclk(sclk_q), .din(din_q),
    .chain_en(chain_en_i), .rb_load(rb_pend), .rb_word(rb_word), .sdo(sdo_o),
    .frame_start(frame_start), .frame_good(frame_good), .frame_word(frame_word),
    .frame_cnt(frame_cnt)
  );

  crp_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .frame_start(frame_start), .frame_good(frame_good),
    .frame_word(frame_word), .wr_stb(wr_stb_o), .wr_req(wr_req), .rb_pend(rb_pend),
    .rb_word(rb_word)
  );

  assign wr_addr_o = wr_req.addr;
  assign wr_sel_o  = wr_req.sel;
  assign wr_data_o = wr_req.data;
endmodule

// File: rtl/chain_regport_chk.sv
module chain_regport_chk
  import crp_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic               sync_q,
  input logic               chain_en_i,
  input logic               sdo_o,
  input logic               wr_stb_o,
  input logic [5:0]         wr_addr_o,
  input logic [1:0]         wr_sel_o,
  input logic [CNT_W-1:0]   frame_cnt,
  input logic [FRAME_W-1:0] frame_word,
  input logic               frame_start,
  input logic               rb_pend
);
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_stb_o |=> !wr_stb_o); // R2
  AST_STB_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_stb_o |-> $past(frame_cnt) == CNT_W'(FRAME_W)); // R3
  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!chain_en_i && sync_q && $past(sync_q)) |-> !sdo_o); // R5
  AST_RB_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rb_pend && frame_start) |=> !rb_pend); // R7
  AST_STB_SEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_stb_o |-> wr_sel_o != 2'b00); // R9
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(sync_q) |-> $stable(frame_word)); // R10
  AST_STB_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_stb_o |-> {1'b0, wr_addr_o} < 7'(NCH)); // R11
endmodule

bind chain_regport chain_regport_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .sync_q(sync_q), .chain_en_i(chain_en_i),
  .sdo_o(sdo_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_sel_o(wr_sel_o),
  .frame_cnt(frame_cnt), .frame_word(frame_word), .frame_start(frame_start),
  .rb_pend(rb_pend)
);

// File: tb/chain_regport_test.sv
module chain_regport_test;
  localparam int HALF = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b1, din = 1'b0, chain_en = 1'b0;
  logic sdo_a, sdo_b, sdo_c;
  logic stb_a, stb_b, stb_c;
  logic [5:0] ad_a, ad_b, ad_c;
  logic [1:0] se_a, se_b, se_c;
  logic [11:0] da_a, da_b, da_c;
  int n_a = 0, n_b = 0, n_c = 0;
  logic [19:0] last_a = '0, last_b = '0, last_c = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chain_regport uut (.clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk),
    .din_i(din), .chain_en_i(chain_en), .sdo_o(sdo_a), .wr_stb_o(stb_a),
    .wr_addr_o(ad_a), .wr_sel_o(se_a), .wr_data_o(da_a));
  chain_regport dut_b (.clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk),
    .din_i(sdo_a), .chain_en_i(chain_en), .sdo_o(sdo_b), .wr_stb_o(stb_b),
    .wr_addr_o(ad_b), .wr_sel_o(se_b), .wr_data_o(da_b));
  chain_regport dut_c (.clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk),
    .din_i(sdo_b), .chain_en_i(chain_en), .sdo_o(sdo_c), .wr_stb_o(stb_c),
    .wr_addr_o(ad_c), .wr_sel_o(se_c), .wr_data_o(da_c));

  always @(posedge clk) begin
    if (stb_a) begin n_a <= n_a + 1; last_a <= {ad_a, se_a, da_a}; end
    if (stb_b) begin n_b <= n_b + 1; last_b <= {ad_b, se_b, da_b}; end
    if (stb_c) begin n_c <= n_c + 1; last_c <= {ad_c, se_c, da_c}; end
  end

  // {word, strobe expected, addr, sel, data}
  localparam logic [44:0] VEC [8] = '{
    {24'h03CA5C, 1'b1, 6'd3, 2'd3, 12'hA5C},
    {24'h004123, 1'b1, 6'd0, 2'd1, 12'h123},
    {24'h078FFF, 1'b1, 6'd7, 2'd2, 12'hFFF},
    {24'h08C111, 1'b0, 6'd0, 2'd0, 12'h000},
    {24'h000000, 1'b0, 6'd0, 2'd0, 12'h000},
    {24'h050777, 1'b0, 6'd0, 2'd0, 12'h000},
    {24'h82C001, 1'b1, 6'd2, 2'd3, 12'h001},
    {24'h014800, 1'b1, 6'd1, 2'd1, 12'h800}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [127:0] tx, input int n, output logic [127:0] rx,
                      output logic early);
    rx = '0;
    sync_n = 1'b0;
    wait_half();
    early = sdo_a;
    for (int i = 0; i < n; i++) begin
      din = tx[n-1-i];
      wait_half();
      rx[n-1-i] = sdo_a;
      sclk = 1'b0;
      wait_half();
      sclk = 1'b1;
    end
    wait_half();
    sync_n = 1'b1;
    din = 1'b0;
    repeat (4) wait_half();
  endtask

  task automatic readback(input logic [23:0] req, input logic [23:0] exp, input string tag,
                          input bit chk_early);
    logic [127:0] rx;
    logic early;
    int n0;
    n0 = n_a;
    xfer({104'd0, req}, 24, rx, early);
    check(n_a == n0, "R9 read request strobe", 64'(n_a - n0), 64'd0);
    n0 = n_a;
    xfer(128'd0, 24, rx, early);
    check(rx[23:0] == exp, tag, 64'(rx[23:0]), 64'(exp));
    check(n_a == n0, "R9 nop strobe", 64'(n_a - n0), 64'd0);
    if (chk_early) check(early == exp[23], "R8 first bit at select fall", 64'(early), 64'(exp[23]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] rx;
    logic early;
    int n0, nb0, nc0;
    logic [71:0] ctx;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sdo_a == 1'b0, "R1 sdo after reset", 64'(sdo_a), 64'd0);
    check(stb_a == 1'b0 && n_a == 0, "R1 strobe after reset", 64'(n_a), 64'd0);

    // R2, R5, R9, R11 from the vector table
    for (int v = 0; v < 8; v++) begin
      n0 = n_a;
      xfer({104'd0, VEC[v][44:21]}, 24, rx, early);
      check((n_a - n0) == int'(VEC[v][20]), "R2/R9/R11 strobe count",
            64'(n_a - n0), 64'(VEC[v][20]));
      if (VEC[v][20])
        check(last_a == VEC[v][19:0], "R2 strobe fields", 64'(last_a), 64'(VEC[v][19:0]));
      check(rx[23:0] == 24'd0, "R5 sdo quiet without chaining", 64'(rx[23:0]), 64'd0);
    end

    // R3: short frame dropped
    n0 = n_a;
    xfer({105'd0, 23'h03C999 >> 0}, 23, rx, early);
    check(n_a == n0, "R3 short frame strobe", 64'(n_a - n0), 64'd0);
    readback(24'h43C000, 24'h43CA5C, "R3/R7 register kept after short frame", 1'b1);

    // R7, R8 readback paths
    readback(24'hC78000, 24'hC78FFF, "R7 offset readback", 1'b1);
    readback(24'h404ABC, 24'h404123, "R7 gain ch0 readback", 1'b1);
    readback(24'h48C000, 24'h48C000, "R11 out of range read", 1'b0);

    // R7: readback frame that is also a write
    xfer({104'd0, 24'h414000}, 24, rx, early);
    n0 = n_a;
    xfer({104'd0, 24'h064456}, 24, rx, early);
    check(rx[23:0] == 24'h414800, "R7 readback during write", 64'(rx[23:0]), 64'h414800);
    check(n_a == n0 + 1 && last_a == {6'd6, 2'd1, 12'h456}, "R2 write in readback frame",
          64'(last_a), 64'({6'd6, 2'd1, 12'h456}));

    // R6: long frame keeps the last 24 bits
    n0 = n_a;
    xfer({98'd0, 6'b111111, 24'h05C3C3}, 30, rx, early);
    check(n_a == n0 + 1 && last_a == {6'd5, 2'd3, 12'h3C3}, "R6 long frame fields",
          64'(last_a), 64'({6'd5, 2'd3, 12'h3C3}));
    check(rx[29:0] == 30'd0, "R5 sdo quiet in long frame", 64'(rx[29:0]), 64'd0);

    // R10: clock edges while select is high
    n0 = n_a;
    din = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wait_half();
      sclk = 1'b0;
      wait_half();
      sclk = 1'b1;
      check(sdo_a == 1'b0, "R10 sdo while deselected", 64'(sdo_a), 64'd0);
    end
    din = 1'b0;
    repeat (4) wait_half();
    check(n_a == n0, "R10 no strobe while deselected", 64'(n_a - n0), 64'd0);
    readback(24'h45C000, 24'h45C3C3, "R6/R10 data register after long frame", 1'b1);

    // R4: three-port chain
    chain_en = 1'b1;
    repeat (4) wait_half();
    n0 = n_a; nb0 = n_b; nc0 = n_c;
    ctx = {24'h06C00C, 24'h044BBB, 24'h03CAAA};
    xfer({56'd0, ctx}, 72, rx, early);
    check(rx[47:0] == ctx[71:24], "R4 shift-through delay", 64'(rx[47:0]), 64'(ctx[71:24]));
    check(n_a == n0 + 1 && last_a == {6'd3, 2'd3, 12'hAAA}, "R4 first port word",
          64'(last_a), 64'({6'd3, 2'd3, 12'hAAA}));
    check(n_b == nb0 + 1 && last_b == {6'd4, 2'd1, 12'hBBB}, "R4 second port word",
          64'(last_b), 64'({6'd4, 2'd1, 12'hBBB}));
    check(n_c == nc0 + 1 && last_c == {6'd6, 2'd3, 12'h00C}, "R4 third port word",
          64'(last_c), 64'({6'd6, 2'd3, 12'h00C}));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule